// File: doc/BRIEF.md
# Quad I/O Read Device Path

This block is the device side of a flash read path in which only the command byte travels on one wire. It watches a chip-select and a serial clock, both sampled in the system clock domain. A read opens with one opcode, shifted in one bit per falling clock edge on line 0. After that opcode, everything moves one nibble per falling edge on four lines:

- the 24-bit start address,
- a mode byte,
- two dummy bytes,
- the returned data.

The block takes its data from a byte-wide, combinational memory read port. Each byte goes out as two nibbles, upper nibble first, and the read pointer advances after each byte.

The mode byte selects what the next transaction looks like. If its upper nibble is 0xA when chip-select rises, the device stays in continuous-read mode. The next transaction then starts directly with the address nibbles and has no opcode. Any other mode value sends the device back to waiting for a serial opcode.

A busy input blanks array data while an internal write cycle is running. The four data lines are driven only in the data phase.

Top module: `quad_read_dev`

## Requirements
- R1: After reset the output enable is low, the read pointer is zero and the device waits for a serial opcode.
- R2: The opcode is taken from dq line 0, MSB first, one bit per sclk falling edge. Only 0xEB starts a read. Any other opcode leaves the data lines undriven until chip-select rises.
- R3: The 24-bit address arrives as six nibbles, most significant nibble first, one per falling edge. It is masked to MEM_AW bits and appears on the memory address port from the edge that completes it.
- R4: The data lines stay undriven (output enable low) through the opcode, address, mode and dummy phases. They are driven from the falling edge that completes 56 counted bits, measured from the opcode's first bit.
- R5: Each data byte is presented upper nibble first, then lower nibble. Each nibble holds from one falling edge to the next, and successive bytes come from consecutive addresses.
- R6: The read pointer wraps from the top of the array to zero.
- R7: When chip-select rises after a mode byte whose upper nibble is 0xA, the next transaction skips the opcode. Its address starts at the first falling edge, and data is driven after 48 counted bits.
- R8: When chip-select rises after a mode byte whose upper nibble is not 0xA, the next transaction needs the serial opcode 0xEB again. Address-first traffic is then ignored.
- R9: While busy_i is high at a byte fetch, the byte sent is 0x00 and the read pointer does not advance.
- R10: Chip-select high ends the transaction, and the output enable is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Active-low chip-select |
| sclk_i | input | 1 | Serial clock, idle high; inputs sampled on falling edges |
| dq_i | input | 4 | Data lines into the device (line 0 carries the opcode) |
| dq_o | output | 4 | Data nibble out of the device |
| dq_oe_o | output | 1 | Output enable for dq_o (high only in the data phase) |
| mem_addr_o | output | MEM_AW | Memory read address (read pointer) |
| mem_data_i | input | 8 | Memory read data for mem_addr_o, combinational |
| busy_i | input | 1 | Array busy; blanks data and holds the pointer |

## Verification
A wrong bit counter or phase state shows up on the first sclk edge where the output enable rises early or late. The scoreboard then compares a nibble one position off and fails within that same serial clock. A continuous-mode flag that is latched wrongly shows up in the next chip-select cycle: the data lines either stay silent or start driving, whichever is wrong. A pointer that steps wrongly under busy, or fails to wrap, shows up as a wrong byte value one fetch later.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_QUAD = 2'd1,
    PH_DATA = 2'd2,
    PH_IDLE = 2'd3
  } qrd_phase_e;

  localparam logic [7:0] QRD_OPCODE   = 8'hEB;
  localparam logic [3:0] QRD_CONT_NIB = 4'hA;
endpackage

// File: rtl/qrd_edge.sv
module qrd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  output logic sclk_fall_o,
  output logic csn_rise_o
);
  logic sclk_q, csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i & ~csn_i;
  assign csn_rise_o  = ~csn_q & csn_i;
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              csn_rise_i,
  input  logic              sclk_fall_i,
  input  logic [3:0]        dq_i,
  output logic              addr_load_o,
  output logic [ADDR_W-1:0] addr_val_o,
  output logic              data_start_o,
  output logic              in_data_o
);
  localparam int ADDR_END = 8 + ADDR_W;
  localparam int MODE_END = ADDR_END + 8;
  localparam int HDR_END  = MODE_END + 16;
  localparam int CNT_W    = $clog2(HDR_END + 1);
  localparam logic [CNT_W-1:0] OPC_C      = CNT_W'(8);
  localparam logic [CNT_W-1:0] ADDR_END_C = CNT_W'(ADDR_END);
  localparam logic [CNT_W-1:0] MODE_END_C = CNT_W'(MODE_END);
  localparam logic [CNT_W-1:0] HDR_END_C  = CNT_W'(HDR_END);

  qrd_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q, cnt_step;
  logic [ADDR_W-5:0] sh_q;
  logic              mode_ok_q, cont_q, cont_nxt, quad_fall;
  logic [7:0]        opc_word;

  // continuous mode presets the count past the skipped opcode
  assign cont_nxt     = csn_rise_i ? mode_ok_q : cont_q;
  assign quad_fall    = sclk_fall_i && (phase_q == PH_QUAD);
  assign cnt_step     = cnt_q + CNT_W'(4);
  assign opc_word     = {sh_q[6:0], dq_i[0]};
  assign addr_val_o   = {sh_q, dq_i};
  assign addr_load_o  = quad_fall && (cnt_step == ADDR_END_C);
  assign data_start_o = quad_fall && (cnt_step == HDR_END_C);
  assign in_data_o    = (phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_OPC;
      cnt_q     <= '0;
      sh_q      <= '0;
      mode_ok_q <= 1'b0;
      cont_q    <= 1'b0;
    end else begin
      if (csn_rise_i) cont_q <= mode_ok_q;
      if (csn_i) begin
        phase_q   <= cont_nxt ? PH_QUAD : PH_OPC;
        cnt_q     <= cont_nxt ? OPC_C : '0;
        mode_ok_q <= 1'b0;
      end else if (sclk_fall_i) begin
        unique case (phase_q)
          PH_OPC: begin
            sh_q  <= {sh_q[ADDR_W-6:0], dq_i[0]};
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == OPC_C - CNT_W'(1))
              phase_q <= (opc_word == QRD_OPCODE) ? PH_QUAD : PH_IDLE;
          end
          PH_QUAD: begin
            sh_q  <= {sh_q[ADDR_W-9:0], dq_i};
            cnt_q <= cnt_step;
            if (cnt_step == MODE_END_C) mode_ok_q <= (sh_q[3:0] == QRD_CONT_NIB);
            if (cnt_step == HDR_END_C) phase_q <= PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qrd_dout.sv
module qrd_dout #(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic              data_start_i,
  input  logic              in_data_i,
  input  logic              busy_i,
  input  logic [7:0]        mem_data_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o
);
  logic [MEM_AW-1:0] ptr_q;
  logic [7:0]        byte_q;
  logic              hi_q, fetch;

  assign fetch = data_start_i | (sclk_fall_i & in_data_i & ~hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      byte_q <= '0;
      hi_q   <= 1'b0;
    end else begin
      if (addr_load_i) ptr_q <= addr_val_i[MEM_AW-1:0];
      if (fetch) begin
        byte_q <= busy_i ? 8'h00 : mem_data_i;
        if (!busy_i) ptr_q <= ptr_q + MEM_AW'(1); // wraps at array top
        hi_q   <= 1'b1;
      end else if (sclk_fall_i && in_data_i) begin
        hi_q <= 1'b0;
      end
    end
  end

  assign mem_addr_o = ptr_q;
  assign dq_o       = hi_q ? byte_q[7:4] : byte_q[3:0];
  assign dq_oe_o    = in_data_i;
endmodule

// File: rtl/quad_read_dev.sv
module quad_read_dev #(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  input  logic              busy_i
);
  logic              sclk_fall, csn_rise, addr_load, data_start, in_data;
  logic [ADDR_W-1:0] addr_val;

  qrd_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .csn_i      (csn_i),
    .sclk_fall_o(sclk_fall),
    .csn_rise_o (csn_rise)
  );

  qrd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csn_i       (csn_i),
    .csn_rise_i  (csn_rise),
    .sclk_fall_i (sclk_fall),
    .dq_i        (dq_i),
    .addr_load_o (addr_load),
    .addr_val_o  (addr_val),
    .data_start_o(data_start),
    .in_data_o   (in_data)
  );

  qrd_dout #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_fall_i (sclk_fall),
    .addr_load_i (addr_load),
    .addr_val_i  (addr_val),
    .data_start_i(data_start),
    .in_data_i   (in_data),
    .busy_i      (busy_i),
    .mem_data_i  (mem_data_i),
    .mem_addr_o  (mem_addr_o),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );
endmodule

// File: rtl/quad_read_dev_chk.sv
module quad_read_dev_chk #(
  parameter int MEM_AW = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              sclk_fall_i,
  input logic              busy_i,
  input logic [3:0]        dq_o,
  input logic              dq_oe_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  assert_oe_off_after_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> !dq_oe_o);

  assert_oe_rise_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(sclk_fall_i));

  assert_nibble_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o) && !$past(sclk_fall_i)) |-> $stable(dq_o));

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o) && !$stable(mem_addr_o))
      |-> mem_addr_o == MEM_AW'($past(mem_addr_o) + 1'b1));

  assert_addr_hold_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && busy_i) |=> $stable(mem_addr_o));

  assert_addr_only_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall_i |=> $stable(mem_addr_o));
endmodule

bind quad_read_dev quad_read_dev_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .csn_i      (csn_i),
  .sclk_fall_i(sclk_fall),
  .busy_i     (busy_i),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/quad_read_dev_bench.sv
module quad_read_dev_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csn_i = 1'b1;
  logic        sclk_i = 1'b1;
  logic [3:0]  dq_i = 4'h0;
  logic        busy_i = 1'b0;
  logic [3:0]  dq_o;
  logic        dq_oe_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  int checks = 0;
  int fails = 0;
  logic [3:0] exp_nib_q[$];
  string      exp_tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  assign mem_data_i = mem_f(mem_addr_o);

  quad_read_dev u_quad_read_dev (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn_i), .sclk_i(sclk_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .busy_i(busy_i)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: master samples on rising sclk
  always @(posedge sclk_i) begin
    if (csn_i === 1'b0 && dq_oe_o === 1'b1) begin
      if (exp_nib_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected drive", {28'd0, dq_o}, 32'hFFFF_FFFF);
      end else begin
        automatic logic [3:0] e = exp_nib_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        chk(dq_o === e, t, "data nibble", {28'd0, dq_o}, {28'd0, e});
      end
    end
  end

  task automatic push_byte(logic [7:0] b, string tag);
    exp_nib_q.push_back(b[7:4]); exp_tag_q.push_back(tag);
    exp_nib_q.push_back(b[3:0]); exp_tag_q.push_back(tag);
  endtask

  task automatic nib(logic [3:0] d);
    dq_i = d;
    sclk_i = 1'b0;
    repeat (2) @(negedge clk);
    sclk_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_op(logic [7:0] op);
    for (int i = 7; i >= 0; i--) nib({3'b000, op[i]});
  endtask

  task automatic send_addr(logic [23:0] a);
    for (int i = 5; i >= 0; i--) nib(a[4*i +: 4]);
  endtask

  task automatic cs_low();
    csn_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high(string tag);
    csn_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(dq_oe_o === 1'b0, "R10", "oe after cs high", {31'd0, dq_oe_o}, 0);
    chk(exp_nib_q.size() == 0, tag, "nibbles left", exp_nib_q.size(), 0);
  endtask

  task automatic read_txn(string tag, bit with_op, logic [23:0] a, logic [7:0] mode, int n);
    for (int k = 0; k < n; k++) push_byte(mem_f(a + 24'(k)), tag);
    cs_low();
    if (with_op) send_op(8'hEB);
    send_addr(a);
    chk(mem_addr_o === a, "R3", "address capture", {8'd0, mem_addr_o}, {8'd0, a});
    nib(mode[7:4]);
    nib(mode[3:0]);
    for (int i = 0; i < 3; i++) nib(4'h0);
    chk(dq_oe_o === 1'b0, "R4", "oe before last dummy", {31'd0, dq_oe_o}, 0);
    nib(4'h0);
    for (int i = 0; i < 2 * n - 1; i++) nib(4'h0);
    cs_high(tag);
  endtask

  // address-first traffic that must be ignored
  task automatic ignored_txn(string tag);
    cs_low();
    send_addr(24'h000000);
    nib(4'hA); nib(4'h0);
    for (int i = 0; i < 8; i++) nib(4'h0);
    chk(dq_oe_o === 1'b0, tag, "oe during ignored txn", {31'd0, dq_oe_o}, 0);
    cs_high(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(dq_oe_o === 1'b0, "R1", "oe after reset", {31'd0, dq_oe_o}, 0);
    chk(mem_addr_o === 24'd0, "R1", "pointer after reset", {8'd0, mem_addr_o}, 0);

    read_txn("R5", 1'b1, 24'h123456, 8'h00, 3);
    ignored_txn("R8");

    // wrong opcode on line 0
    cs_low();
    send_op(8'h0B);
    for (int i = 0; i < 16; i++) nib(4'hF);
    chk(dq_oe_o === 1'b0, "R2", "oe after bad opcode", {31'd0, dq_oe_o}, 0);
    cs_high("R2");

    read_txn("R6", 1'b1, 24'hFFFFFE, 8'hA5, 4);
    read_txn("R7", 1'b0, 24'h00ABCD, 8'hAF, 2);

    // busy blanking, still in continuous mode; mode 0x12 exits it
    push_byte(mem_f(24'h000200), "R9");
    push_byte(8'h00, "R9");
    push_byte(8'h00, "R9");
    push_byte(mem_f(24'h000201), "R9");
    cs_low();
    send_addr(24'h000200);
    nib(4'h1); nib(4'h2);
    for (int i = 0; i < 4; i++) nib(4'h0);
    nib(4'h0);
    busy_i = 1'b1;
    for (int i = 0; i < 4; i++) nib(4'h0);
    chk(mem_addr_o === 24'h000201, "R9", "pointer held while busy", {8'd0, mem_addr_o}, 32'h201);
    busy_i = 1'b0;
    nib(4'h0); nib(4'h0);
    cs_high("R9");

    ignored_txn("R8");
    read_txn("R2", 1'b1, 24'h000010, 8'h00, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule